// File: doc/BRIEF.md
# SDRAM Single-Access Command Sequencer

This block turns one memory request at a time into the command sequence a synchronous DRAM expects: open the row, perform one column access, then close the row. Each request carries a write flag, bank, row, column, one word of write data and a per-byte mask. The block owns the command pins, the address and bank pins, the per-byte mask pins and the write-data drive. It returns read data through a one-cycle valid strobe. Every access is closed again before the next one is taken, so the next request always starts from a precharged bank.

All spacing rules are counted in clocks by small down-counters. The rules are:

- row-open to column command;
- minimum row-open time before close;
- write recovery before close;
- close-to-open recovery;
- open-to-open spacing, one value for the same bank and one for a different bank.

Read latency is two or three clocks, chosen per request by `cl_is3` and held with the request. A separate refresh sequencer stalls the block through `refresh_hold`, which keeps the request port closed.

The controller has five states. ST_IDLE waits for a request. ST_OPEN issues the row-open command once the open-to-open spacing allows it. ST_ACCESS issues the read or write once the row-to-column delay has run out. ST_CLOSE issues the precharge once the row has been open long enough and write recovery is complete. ST_RECOVER waits out the precharge time and then returns to ST_IDLE.

The transitions are:

- IDLE→OPEN on an accepted request;
- OPEN→ACCESS when the open command issues;
- ACCESS→CLOSE when the column command issues;
- CLOSE→RECOVER when the precharge issues;
- RECOVER→IDLE when the precharge timer expires.

Top module: `sdram_single_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `rd_valid` is 0, `sd_dq_oe` is 0, `sd_dqm` is 0, and the command pins {cs_n,ras_n,cas_n,we_n} read 0111 (no operation).
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 whenever `refresh_hold` is 1. `req_ready` is also 0 from the cycle after acceptance until the ready cycle given in R10. Requests presented while `req_ready` is 0 issue no command and do not change the request that is in flight.
- R3: The row-open command (0011) appears in the cycle after acceptance, provided the spacing rules of R9 allow it. During that cycle `sd_ba` carries the bank and `sd_addr` carries the row.
- R4: The column command appears exactly T_RCD=2 clocks after the row-open command. It is 0101 for a read and 0100 for a write. `sd_addr` carries the column zero-extended, with bit 10 at 0 (no auto-close), and `sd_ba` carries the same bank.
- R5: In the write command cycle `sd_dq_oe` is 1, `sd_dq_out` equals the write data and `sd_dqm` equals the byte mask (mask latency 0; bit b set masks byte b). `sd_dq_oe` is 0 in every other cycle.
- R6: CAS latency is 2 when `cl_is3` was 0 at acceptance and 3 otherwise. For a read, `rd_valid` is 1 for exactly one cycle, CL+1 clocks after the read command. `rd_data` then holds the DQ value present CL clocks after the read command, with every byte whose mask bit is set forced to 0x00.
- R7: For a read, `sd_dqm` equals the byte mask in the single cycle CL-2 clocks after the read command. This follows from the read-disable latency of 2. `sd_dqm` is 0 in every cycle that is neither this one nor a write command cycle.
- R8: The precharge command (0010, address bit 10 at 0, same bank) issues in the first cycle that is at least T_RAS=6 clocks after the row-open and, for a write, at least T_DPL=2 clocks after the write command.
- R9: A row-open command is at least T_RP=3 clocks after the previous precharge. It is also at least T_DPL+T_RP=5 clocks after the previous write command. It is at least T_RC=8 clocks after the previous row-open to the same bank, and at least T_RRD=2 clocks after the previous row-open to any other bank.
- R10: `req_ready` returns to 1 (with `refresh_hold` at 0) exactly T_RP+1 clocks after the precharge command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | BANK_W | Bank of the access |
| req_row | input | ROW_W | Row of the access |
| req_col | input | COL_W | Column of the access |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Byte mask, bit set = byte masked |
| cl_is3 | input | 1 | CAS latency select, 0 = two clocks, 1 = three |
| refresh_hold | input | 1 | Refresh sequencer holds the block off |
| rd_valid | output | 1 | One-cycle strobe for read data |
| rd_data | output | DATA_W | Captured read word |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BANK_W | Bank address |
| sd_addr | output | ROW_W | Row / column address |
| sd_dqm | output | DATA_W/8 | Per-byte data mask |
| sd_dq_out | output | DATA_W | Write data to the DQ pins |
| sd_dq_oe | output | 1 | DQ output enable |
| sd_dq_in | input | DATA_W | Read data from the DQ pins |

## Verification
A wrong state or a wrong timer value shows up on the command pins within a few clocks. The row-open, column or precharge command moves by one or more cycles against the fixed schedule counted from acceptance. It is caught in the same cycle it appears, because the bench predicts the exact cycle of each command.

A fault in the latency pipeline shows up within CL+1 clocks of the read command in one of two ways. The strobe may move off its cycle. The data may come from a cycle whose DQ value is deliberately junk and so fails the comparison.

A fault in mask handling shows up as a wrong byte in `rd_data`, or as a `sd_dqm` value in the wrong cycle. A fault in the ready logic shows up as an early `req_ready` inside the busy window, or a late one at the predicted return cycle.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_ACCESS,
        ST_CLOSE,
        ST_RECOVER
    } sdc_state_e;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP = 4'b0111;
    localparam logic [3:0] CMD_ACT = 4'b0011;
    localparam logic [3:0] CMD_RD  = 4'b0101;
    localparam logic [3:0] CMD_WR  = 4'b0100;
    localparam logic [3:0] CMD_PRE = 4'b0010;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sdc_wait_timer.sv
`timescale 1ns/1ps
module sdc_wait_timer #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/sdc_rd_capture.sv
`timescale 1ns/1ps
module sdc_rd_capture #(
    parameter int DATA_W = 16,
    localparam int NBYTE = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [NBYTE-1:0]  mask_in,
    input  logic              cl3_in,
    input  logic [DATA_W-1:0] dq_in,
    output logic [NBYTE-1:0]  dqm_rd,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);

    logic [3:1]       stg_v;
    logic [3:1]       stg_c3;
    logic [NBYTE-1:0] stg_m [3:1];
    logic             hit2, hit3, hit;
    logic [NBYTE-1:0] cap_mask;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg_v  <= '0;
            stg_c3 <= '0;
            for (int i = 1; i <= 3; i++) stg_m[i] <= '0;
        end else begin
            stg_v[1]  <= issue;
            stg_c3[1] <= cl3_in;
            stg_m[1]  <= mask_in;
            for (int i = 2; i <= 3; i++) begin
                stg_v[i]  <= stg_v[i-1];
                stg_c3[i] <= stg_c3[i-1];
                stg_m[i]  <= stg_m[i-1];
            end
        end
    end

    assign hit2     = stg_v[2] && !stg_c3[2];
    assign hit3     = stg_v[3] && stg_c3[3];
    assign hit      = hit2 || hit3;
    assign cap_mask = hit3 ? stg_m[3] : stg_m[2];

    // read-disable latency of 2: mask leads the data by two cycles
    always_comb begin
        if (issue && !cl3_in)          dqm_rd = mask_in;
        else if (stg_v[1] && stg_c3[1]) dqm_rd = stg_m[1];
        else                           dqm_rd = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= hit;
    end

    for (genvar b = 0; b < NBYTE; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n)   rd_data[b*8 +: 8] <= 8'h00;
            else if (hit) rd_data[b*8 +: 8] <= cap_mask[b] ? 8'h00 : dq_in[b*8 +: 8];
        end
    end

    AST_RD_ONE_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid); // R6
    AST_CAPTURE_UNIQUE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({hit2, hit3})); // R6
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !(stg_v[1] || stg_v[2])); // R6

endmodule

// File: rtl/sdram_single_ctrl.sv
`timescale 1ns/1ps
module sdram_single_ctrl
    import sdc_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 13,
    parameter int COL_W  = 10,
    parameter int DATA_W = 16,
    parameter int T_RCD  = 2,
    parameter int T_RAS  = 6,
    parameter int T_RC   = 8,
    parameter int T_RRD  = 2,
    parameter int T_DPL  = 2,
    parameter int T_RP   = 3,
    localparam int NBYTE = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [NBYTE-1:0]  req_mask,
    input  logic              cl_is3,
    input  logic              refresh_hold,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr,
    output logic [NBYTE-1:0]  sd_dqm,
    output logic [DATA_W-1:0] sd_dq_out,
    output logic              sd_dq_oe,
    input  logic [DATA_W-1:0] sd_dq_in
);

    localparam int TMAX   = max_of(max_of(max_of(T_RCD, T_RAS), max_of(T_RC, T_RRD)),
                                   max_of(T_DPL, T_RP));
    localparam int TW     = $clog2(TMAX + 1);
    localparam int NT     = 6;
    localparam int TI_RCD = 0;
    localparam int TI_RAS = 1;
    localparam int TI_RC  = 2;
    localparam int TI_RRD = 3;
    localparam int TI_DPL = 4;
    localparam int TI_RP  = 5;
    localparam int HW     = $clog2(TMAX + T_DPL + T_RP + 1);

    sdc_state_e        state, state_nxt;
    logic              r_write, r_cl3;
    logic [BANK_W-1:0] r_bank, last_bank;
    logic [ROW_W-1:0]  r_row;
    logic [COL_W-1:0]  r_col;
    logic [DATA_W-1:0] r_wdata;
    logic [NBYTE-1:0]  r_mask;
    logic [NBYTE-1:0]  dqm_rd;
    logic [3:0]        cmd;
    logic              accept, act_ok, iss_act, iss_col, iss_pre;
    logic [NT-1:0]     t_load, t_zero;
    logic [TW-1:0]     t_val [NT];

    assign req_ready = (state == ST_IDLE) && !refresh_hold;
    assign accept    = req_valid && req_ready;
    assign act_ok    = (r_bank == last_bank) ? t_zero[TI_RC] : t_zero[TI_RRD];
    assign iss_act   = (state == ST_OPEN) && act_ok;
    assign iss_col   = (state == ST_ACCESS) && t_zero[TI_RCD];
    assign iss_pre   = (state == ST_CLOSE) && t_zero[TI_RAS] && t_zero[TI_DPL];

    // spacing timers: each loaded with (rule - 1) on the command it follows
    always_comb begin
        t_val[TI_RCD] = TW'(T_RCD - 1);
        t_val[TI_RAS] = TW'(T_RAS - 1);
        t_val[TI_RC]  = TW'(T_RC - 1);
        t_val[TI_RRD] = TW'(T_RRD - 1);
        t_val[TI_DPL] = TW'(T_DPL - 1);
        t_val[TI_RP]  = TW'(T_RP - 1);
        t_load         = '0;
        t_load[TI_RCD] = iss_act;
        t_load[TI_RAS] = iss_act;
        t_load[TI_RC]  = iss_act;
        t_load[TI_RRD] = iss_act;
        t_load[TI_DPL] = iss_col && r_write;
        t_load[TI_RP]  = iss_pre;
    end

    for (genvar g = 0; g < NT; g++) begin : g_timer
        sdc_wait_timer #(.W(TW)) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (t_load[g]),
            .load_val (t_val[g]),
            .zero     (t_zero[g])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:    if (accept)       state_nxt = ST_OPEN;
            ST_OPEN:    if (iss_act)      state_nxt = ST_ACCESS;
            ST_ACCESS:  if (iss_col)      state_nxt = ST_CLOSE;
            ST_CLOSE:   if (iss_pre)      state_nxt = ST_RECOVER;
            ST_RECOVER: if (t_zero[TI_RP]) state_nxt = ST_IDLE;
            default:                      state_nxt = ST_IDLE;
        endcase
    end

    // request latch and last opened bank
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_write   <= 1'b0;
            r_cl3     <= 1'b0;
            r_bank    <= '0;
            r_row     <= '0;
            r_col     <= '0;
            r_wdata   <= '0;
            r_mask    <= '0;
            last_bank <= '0;
        end else begin
            if (accept) begin
                r_write <= req_write;
                r_cl3   <= cl_is3;
                r_bank  <= req_bank;
                r_row   <= req_row;
                r_col   <= req_col;
                r_wdata <= req_wdata;
                r_mask  <= req_mask;
            end
            if (iss_act) last_bank <= r_bank;
        end
    end

    // outputs
    always_comb begin
        cmd       = CMD_NOP;
        sd_ba     = r_bank;
        sd_addr   = '0;
        sd_dq_oe  = 1'b0;
        sd_dq_out = r_wdata;
        sd_dqm    = dqm_rd;
        unique case (state)
            ST_OPEN: if (iss_act) begin
                cmd     = CMD_ACT;
                sd_addr = r_row;
            end
            ST_ACCESS: if (iss_col) begin
                cmd     = r_write ? CMD_WR : CMD_RD;
                sd_addr = {{(ROW_W-COL_W){1'b0}}, r_col};
                if (r_write) begin
                    sd_dq_oe = 1'b1;
                    sd_dqm   = r_mask;
                end
            end
            ST_CLOSE: if (iss_pre) cmd = CMD_PRE;
            default: ;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;

    sdc_rd_capture #(.DATA_W(DATA_W)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (iss_col && !r_write),
        .mask_in  (r_mask),
        .cl3_in   (r_cl3),
        .dq_in    (sd_dq_in),
        .dqm_rd   (dqm_rd),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // observers: clocks since each command kind, saturating
    logic [HW-1:0] since_act, since_wr, since_pre;
    logic          is_act, is_col, is_wr, is_pre;
    assign is_act = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_ACT);
    assign is_wr  = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_WR);
    assign is_col = is_wr || ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_RD);
    assign is_pre = ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == CMD_PRE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= '1;
            since_wr  <= '1;
            since_pre <= '1;
        end else begin
            since_act <= is_act ? HW'(1) : ((since_act == '1) ? since_act : since_act + 1'b1);
            since_wr  <= is_wr  ? HW'(1) : ((since_wr  == '1) ? since_wr  : since_wr  + 1'b1);
            since_pre <= is_pre ? HW'(1) : ((since_pre == '1) ? since_pre : since_pre + 1'b1);
        end
    end

    AST_RCD_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        is_col |-> (since_act >= HW'(T_RCD))); // R4
    AST_RAS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (since_act >= HW'(T_RAS))); // R8
    AST_WR_RECOVERY: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> (since_wr >= HW'(T_DPL))); // R8
    AST_RP_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> (since_pre >= HW'(T_RP))); // R9
    AST_DAL_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        is_act |-> (since_wr >= HW'(T_DPL + T_RP))); // R9
    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R2
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_hold |-> !req_ready); // R2
    AST_OE_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        sd_dq_oe |-> is_wr); // R5

endmodule

// File: tb/tb_sdram_single_ctrl.sv
`timescale 1ns/1ps
module tb_sdram_single_ctrl;

    localparam int T_RCD = 2, T_RAS = 6, T_RC = 8, T_RRD = 2, T_DPL = 2, T_RP = 3;
    localparam logic [3:0] C_NOP = 4'b0111, C_ACT = 4'b0011, C_RD = 4'b0101,
                           C_WR = 4'b0100, C_PRE = 4'b0010;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, cl_is3 = 1'b0, refresh_hold = 1'b0;
    logic [1:0]  req_bank = '0, req_mask = '0;
    logic [12:0] req_row = '0;
    logic [9:0]  req_col = '0;
    logic [15:0] req_wdata = '0, sd_dq_in = '0;
    logic        req_ready, rd_valid, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
    logic [15:0] rd_data, sd_dq_out;
    logic [1:0]  sd_ba, sd_dqm;
    logic [12:0] sd_addr;

    sdram_single_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bank(req_bank), .req_row(req_row), .req_col(req_col),
        .req_wdata(req_wdata), .req_mask(req_mask), .cl_is3(cl_is3),
        .refresh_hold(refresh_hold), .rd_valid(rd_valid), .rd_data(rd_data),
        .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
        .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
        .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // expected request and command history
    int          acc_cyc = -100, act_cyc = -100, pre_cyc = -100, wr_cyc = -100;
    int          drive_cyc = -100, val_cyc = -100, dqm_cyc = -100;
    logic        e_write = 1'b0, e_cl3 = 1'b0, busy = 1'b0, monitor_on = 1'b0;
    logic [1:0]  e_bank = '0, e_mask = '0, rd_mask = '0, act_bank = '0;
    logic [12:0] e_row = '0;
    logic [9:0]  e_col = '0;
    logic [15:0] e_wdata = '0, drive_val = '0;
    logic [15:0] mem [int];

    function automatic int key_of(logic [1:0] b, logic [12:0] r, logic [9:0] c);
        return int'({7'd0, b, r, c});
    endfunction
    function automatic logic [15:0] init_pat(int k);
        return 16'(k * 40503 + 4660);
    endfunction
    function automatic logic [15:0] keep_bits(logic [1:0] m);
        return {{8{~m[1]}}, {8{~m[0]}}};
    endfunction
    function automatic logic [15:0] merge(logic [15:0] o, logic [15:0] n, logic [1:0] m);
        return (o & ~keep_bits(m)) | (n & keep_bits(m));
    endfunction
    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // bus monitor and memory model, all at the falling edge
    always @(negedge clk) begin
        if (monitor_on) begin
            automatic logic [3:0]  cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            automatic int          k = cyc;
            automatic logic [1:0]  exp_dqm;
            automatic int          key;
            automatic int          pexp;
            case (cmd)
                C_NOP: ;
                C_ACT: begin
                    chk(k == acc_cyc + 1, "R3", "open cycle", k, acc_cyc + 1);
                    chk(sd_ba == e_bank, "R3", "open bank", sd_ba, e_bank);
                    chk(sd_addr == e_row, "R3", "open row", sd_addr, e_row);
                    chk(k - pre_cyc >= T_RP, "R9", "precharge to open", k - pre_cyc, T_RP);
                    chk(k - wr_cyc >= T_DPL + T_RP, "R9", "write to open", k - wr_cyc, T_DPL + T_RP);
                    if (sd_ba == act_bank)
                        chk(k - act_cyc >= T_RC, "R9", "same bank open spacing", k - act_cyc, T_RC);
                    else
                        chk(k - act_cyc >= T_RRD, "R9", "other bank open spacing", k - act_cyc, T_RRD);
                    act_cyc  = k;
                    act_bank = sd_ba;
                end
                C_RD, C_WR: begin
                    chk(k == act_cyc + T_RCD, "R4", "column cycle", k, act_cyc + T_RCD);
                    chk(sd_addr == {3'b000, e_col}, "R4", "column address", sd_addr, {3'b000, e_col});
                    chk(sd_ba == e_bank, "R4", "column bank", sd_ba, e_bank);
                    chk((cmd == C_WR) == e_write, "R4", "column kind", cmd, e_write ? C_WR : C_RD);
                    key = key_of(e_bank, e_row, e_col);
                    if (cmd == C_WR) begin
                        chk(sd_dq_oe && sd_dq_out == e_wdata, "R5", "write data", sd_dq_out, e_wdata);
                        if (!mem.exists(key)) mem[key] = init_pat(key);
                        mem[key] = merge(mem[key], sd_dq_out, sd_dqm);
                        wr_cyc = k;
                    end else begin
                        drive_val = mem.exists(key) ? mem[key] : init_pat(key);
                        drive_cyc = k + (e_cl3 ? 3 : 2);
                        val_cyc   = drive_cyc + 1;
                        dqm_cyc   = drive_cyc - 2;
                        rd_mask   = e_mask;
                    end
                end
                C_PRE: begin
                    pexp = max2(act_cyc + T_RAS, e_write ? wr_cyc + T_DPL : 0);
                    chk(k == pexp, "R8", "precharge cycle", k, pexp);
                    chk(sd_addr[10] == 1'b0 && sd_ba == e_bank, "R8", "precharge bank", sd_ba, e_bank);
                    pre_cyc = k;
                end
                default: chk(1'b0, "R3", "illegal command", cmd, C_NOP);
            endcase
            exp_dqm = (k == dqm_cyc) ? rd_mask : ((cmd == C_WR) ? e_mask : 2'b00);
            chk(sd_dqm == exp_dqm, "R7", "mask pins", sd_dqm, exp_dqm);
            if (sd_dq_oe && cmd != C_WR) chk(1'b0, "R5", "output enable outside write", 1, 0);
            if (k == val_cyc)
                chk(rd_valid && rd_data == (drive_val & keep_bits(rd_mask)), "R6", "read word",
                    {rd_valid, rd_data}, {1'b1, drive_val & keep_bits(rd_mask)});
            else if (rd_valid)
                chk(1'b0, "R6", "stray read strobe", 1, 0);
            if (busy && k > acc_cyc) begin
                if (pre_cyc > acc_cyc && k == pre_cyc + T_RP + 1) begin
                    chk(req_ready == !refresh_hold, "R10", "ready return", req_ready, !refresh_hold);
                    busy = 1'b0;
                end else begin
                    chk(!req_ready, "R2", "ready while busy", req_ready, 0);
                end
            end
            sd_dq_in = (k == drive_cyc) ? drive_val : {cyc[7:0], ~cyc[7:0]};
        end
    end

    task automatic do_req(input logic w, input logic [1:0] b, input logic [12:0] r,
                          input logic [9:0] c, input logic [15:0] d, input logic [1:0] m,
                          input logic cl, input bit poke);
        @(negedge clk);
        req_write = w; req_bank = b; req_row = r; req_col = c;
        req_wdata = d; req_mask = m; cl_is3 = cl; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        acc_cyc = cyc;
        e_write = w; e_bank = b; e_row = r; e_col = c; e_wdata = d; e_mask = m; e_cl3 = cl;
        busy = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (poke) begin
            // R2: requests while busy must be ignored
            req_valid = 1'b1; req_bank = ~b; req_row = ~r; req_write = ~w;
            repeat (3) @(negedge clk);
            req_valid = 1'b0;
        end
        while (busy) @(negedge clk);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
        chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R1", "command after reset",
            {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
        chk(!sd_dq_oe && !rd_valid && sd_dqm == 2'b00, "R1", "idle outputs",
            {sd_dq_oe, rd_valid, sd_dqm}, 0);
        monitor_on = 1'b1;

        // R5 / R6 directed: write, then read back at both latencies
        do_req(1'b1, 2'd1, 13'h1ABC, 10'h155, 16'hBEEF, 2'b00, 1'b0, 1'b0);
        do_req(1'b0, 2'd1, 13'h1ABC, 10'h155, 16'h0000, 2'b00, 1'b0, 1'b0);
        do_req(1'b0, 2'd1, 13'h1ABC, 10'h155, 16'h0000, 2'b00, 1'b1, 1'b0);
        // R7 read masks at both latencies
        do_req(1'b0, 2'd1, 13'h1ABC, 10'h155, 16'h0000, 2'b01, 1'b1, 1'b0);
        do_req(1'b0, 2'd1, 13'h1ABC, 10'h155, 16'h0000, 2'b10, 1'b0, 1'b0);
        // masked write then full read
        do_req(1'b1, 2'd1, 13'h1ABC, 10'h155, 16'h1234, 2'b10, 1'b0, 1'b0);
        do_req(1'b0, 2'd1, 13'h1ABC, 10'h155, 16'h0000, 2'b00, 1'b1, 1'b0);
        // same bank back to back, then different bank, with ignored pokes (R2)
        do_req(1'b1, 2'd3, 13'h0001, 10'h3FF, 16'hA5A5, 2'b11, 1'b0, 1'b1);
        do_req(1'b0, 2'd3, 13'h0001, 10'h3FF, 16'h0000, 2'b00, 1'b0, 1'b1);
        do_req(1'b0, 2'd0, 13'h1FFF, 10'h000, 16'h0000, 2'b00, 1'b1, 1'b0);

        // R2 refresh hold-off
        @(negedge clk);
        refresh_hold = 1'b1; req_valid = 1'b1; req_bank = 2'd2;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk(!req_ready, "R2", "ready under hold", req_ready, 0);
            chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == C_NOP, "R2", "command under hold",
                {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, C_NOP);
        end
        req_valid = 1'b0;
        refresh_hold = 1'b0;
        do_req(1'b0, 2'd2, 13'h0042, 10'h011, 16'h0000, 2'b00, 1'b0, 1'b0);

        // constrained random traffic on a small address set
        for (int n = 0; n < 60; n++) begin
            automatic logic        w  = ($urandom % 3) == 0;
            automatic logic [1:0]  b  = 2'($urandom);
            automatic logic [12:0] r  = 13'($urandom % 4);
            automatic logic [9:0]  c  = 10'($urandom % 8);
            automatic logic [15:0] d  = 16'($urandom);
            automatic logic [1:0]  m  = 2'($urandom);
            automatic logic        cl = 1'($urandom);
            do_req(w, b, r, c, d, m, cl, ($urandom % 8) == 0);
        end

        repeat (8) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_err++;
            $display("FAIL R2 watchdog: run hung actual=0 expected=1");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

endmodule